// File: doc/BRIEF.md
# Page ECC Generator

This block computes a 24-bit single-error-correcting parity code for a NAND page while the page's data streams through it. It runs during a read or a program. The page is split into 512-byte sub-blocks, and each sub-block gets its own code. Data arrives as 32-bit beats, each carrying four bytes in little-endian order. A strobe arms the block for a new page. A marker on the final beat closes the page, and any sub-block still open at that point is closed with it.

Each finished code is stored in one of four result slots, together with a status byte that flags it as valid. Software or a sequencer reads the slots through a small read port that has one cycle of latency. A busy output stays high from the arming strobe until the final code has been stored. Codes should be read once busy has dropped. Beats beyond the fourth sub-block (2048 bytes) are discarded, and a sticky oversize flag marks the page as unsupported.

Top module: `ecc_page_gen`

## Requirements
- R1: Inside a sub-block, each data bit has a 12-bit position `{byte_offset[8:0], bit_index[2:0]}`. Byte k of a beat is `in_data[8k+7:8k]`, and the first byte of a sub-block is byte 0 of its first beat. Code bit k (k = 0..11) is the XOR of all data bits whose position has bit k set. Code bit 12+k is the XOR of all data bits whose position has bit k clear.
- R2: Sub-block n covers page bytes 512n to 512n+511, and its code is stored in result slot n (n = 0..3).
- R3: A valid slot reads as `{8'h40, code[23:0]}`, so status bit 6 (word bit 30) is the valid flag. A slot that is not valid reads as 32'h0.
- R4: A slot becomes valid once the 128th beat of its sub-block has been folded in, even while the page is still streaming. A beat with `in_last` set also closes a partly filled sub-block, and its missing bytes count as zero.
- R5: Busy is high in the cycle after `start`. It stays high until the beat marked `in_last` has been processed, and falls two clock edges after that beat was sampled, on the same edge at which the final slot becomes valid.
- R6: `start` clears every valid flag, the running parity, the sub-block position and the oversize flag, including when it aborts a page part way through.
- R7: Beats that arrive after four full sub-blocks are discarded and set `oversize`, which stays set until the next `start`. The four stored codes are not changed.
- R8: Beats that arrive while the block is not armed (after reset, or after a page has ended) are ignored.
- R9: `rd_data` shows the slot selected by `rd_addr` one clock edge after the address is sampled.
- R10: Cycles in which `in_valid` is low carry no data, so idle gaps between beats do not change any code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Arms the block for a new page and clears earlier results |
| in_valid | input | 1 | A data beat is present |
| in_data | input | 32 | Four page bytes, little-endian |
| in_last | input | 1 | This beat is the final one of the page |
| rd_addr | input | 2 | Result slot to read |
| rd_data | output | 32 | Status byte and 24-bit code of the selected slot |
| busy | output | 1 | A page code is still being computed |
| oversize | output | 1 | The page ran past 2048 bytes |

## Verification
The checks assume that `start` never coincides with a beat; one property enforces this as an input rule. They also assume that a page ends with a single beat marked `in_last`, since the busy-fall property ties each falling edge of busy to such a beat two edges earlier. The stimulus drives `start` only in cycles with no beat. It marks `in_last` on exactly one beat per page. Stray beats sent after a page has ended may carry the marker, but they arrive while busy is already low, so they cannot produce a falling edge. Page lengths are whole beats, and they include a partial sub-block, an exact 2048-byte page and an overlong page.

// File: rtl/ecc_page_pkg.sv
package ecc_page_pkg;

  localparam int STATUS_W = 8;
  localparam int VALID_POS = 6;

  function automatic logic [STATUS_W-1:0] status_byte(input logic ok);
    logic [STATUS_W-1:0] s;
    s = '0;
    s[VALID_POS] = ok;
    return s;
  endfunction

endpackage

// File: rtl/ecc_beat_stage.sv
module ecc_beat_stage #(
  parameter int DATA_W     = 32,
  parameter int BEAT_IDX_W = 7,
  parameter int SUB_W      = 2,
  localparam int LOC_W     = $clog2(DATA_W),
  localparam int HALF_W    = LOC_W + BEAT_IDX_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clear,
  input  logic                  fwd,
  input  logic                  use_data,
  input  logic                  close,
  input  logic                  last,
  input  logic [SUB_W-1:0]      sub,
  input  logic [BEAT_IDX_W-1:0] beat_idx,
  input  logic [DATA_W-1:0]     data,
  output logic                  s_valid,
  output logic                  s_close,
  output logic                  s_last,
  output logic [SUB_W-1:0]      s_sub,
  output logic [HALF_W-1:0]     s_odd,
  output logic [HALF_W-1:0]     s_even
);

  logic [HALF_W-1:0] odd_c, even_c;
  logic              word_par;

  assign word_par = ^data;

  // Low position bits come from the bit's place inside the beat,
  // high position bits come from the beat index inside the sub-block.
  for (genvar k = 0; k < HALF_W; k++) begin : g_bit
    if (k < LOC_W) begin : g_local
      always_comb begin
        odd_c[k]  = 1'b0;
        even_c[k] = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
          if (((i >> k) & 1) == 1) odd_c[k] = odd_c[k] ^ data[i];
          else                     even_c[k] = even_c[k] ^ data[i];
        end
      end
    end else begin : g_line
      assign odd_c[k]  = beat_idx[k-LOC_W] ? word_par : 1'b0;
      assign even_c[k] = beat_idx[k-LOC_W] ? 1'b0 : word_par;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      s_valid <= 1'b0;
      s_close <= 1'b0;
      s_last  <= 1'b0;
      s_sub   <= '0;
      s_odd   <= '0;
      s_even  <= '0;
    end else begin
      s_valid <= fwd;
      s_close <= use_data && close;
      s_last  <= fwd && last;
      s_sub   <= sub;
      s_odd   <= use_data ? odd_c : '0;
      s_even  <= use_data ? even_c : '0;
    end
  end

endmodule

// File: rtl/ecc_accum.sv
module ecc_accum #(
  parameter int HALF_W = 12,
  parameter int SUB_W  = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clear,
  input  logic                s_valid,
  input  logic                s_close,
  input  logic [SUB_W-1:0]    s_sub,
  input  logic [HALF_W-1:0]   s_odd,
  input  logic [HALF_W-1:0]   s_even,
  output logic                wr_en,
  output logic [SUB_W-1:0]    wr_idx,
  output logic [2*HALF_W-1:0] wr_code
);

  logic [HALF_W-1:0] acc_odd, acc_even;
  logic [HALF_W-1:0] nxt_odd, nxt_even;

  assign nxt_odd  = acc_odd ^ s_odd;
  assign nxt_even = acc_even ^ s_even;
  assign wr_en    = s_valid && s_close && !clear;
  assign wr_idx   = s_sub;
  assign wr_code  = {nxt_even, nxt_odd};

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      acc_odd  <= '0;
      acc_even <= '0;
    end else if (s_valid) begin
      if (s_close) begin
        acc_odd  <= '0;
        acc_even <= '0;
      end else begin
        acc_odd  <= nxt_odd;
        acc_even <= nxt_even;
      end
    end
  end

endmodule

// File: rtl/ecc_result_bank.sv
module ecc_result_bank
  import ecc_page_pkg::*;
#(
  parameter int NUM_SUB = 4,
  parameter int CODE_W  = 24,
  localparam int SUB_W  = $clog2(NUM_SUB),
  localparam int WORD_W = CODE_W + STATUS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              wr_en,
  input  logic [SUB_W-1:0]  wr_idx,
  input  logic [CODE_W-1:0] wr_code,
  input  logic [SUB_W-1:0]  rd_addr,
  output logic [WORD_W-1:0] rd_data
);

  logic [CODE_W-1:0]  mem [NUM_SUB];
  logic [NUM_SUB-1:0] vld;

  // Code storage has no reset so it can map onto RAM.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_code;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) vld <= '0;
    else if (wr_en)   vld[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)               rd_data <= '0;
    else if (vld[rd_addr]) rd_data <= {status_byte(1'b1), mem[rd_addr]};
    else                   rd_data <= '0;
  end

endmodule

// File: rtl/ecc_page_gen.sv
module ecc_page_gen #(
  parameter int DATA_W    = 32,
  parameter int SUB_BYTES = 512,
  parameter int NUM_SUB   = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  input  logic                       in_valid,
  input  logic [DATA_W-1:0]          in_data,
  input  logic                       in_last,
  input  logic [$clog2(NUM_SUB)-1:0] rd_addr,
  output logic [31:0]                rd_data,
  output logic                       busy,
  output logic                       oversize
);

  localparam int BEAT_BYTES    = DATA_W / 8;
  localparam int BEATS_PER_SUB = SUB_BYTES / BEAT_BYTES;
  localparam int BEAT_IDX_W    = $clog2(BEATS_PER_SUB);
  localparam int LOC_W         = $clog2(DATA_W);
  localparam int HALF_W        = LOC_W + BEAT_IDX_W;
  localparam int CODE_W        = 2 * HALF_W;
  localparam int SUB_W         = $clog2(NUM_SUB);
  localparam int CNT_W         = $clog2(NUM_SUB + 1);

  logic                  armed;
  logic [CNT_W-1:0]      sub_idx;
  logic [BEAT_IDX_W-1:0] beat_idx;
  logic                  accept, drop, use_data, close;

  logic                  s_valid, s_close, s_last;
  logic [SUB_W-1:0]      s_sub;
  logic [HALF_W-1:0]     s_odd, s_even;
  logic                  wr_en;
  logic [SUB_W-1:0]      wr_idx;
  logic [CODE_W-1:0]     wr_code;

  assign accept   = in_valid && armed && !start;
  assign drop     = (sub_idx == CNT_W'(NUM_SUB));
  assign use_data = accept && !drop;
  assign close    = (beat_idx == BEAT_IDX_W'(BEATS_PER_SUB - 1)) || in_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed    <= 1'b0;
      sub_idx  <= '0;
      beat_idx <= '0;
      oversize <= 1'b0;
      busy     <= 1'b0;
    end else if (start) begin
      armed    <= 1'b1;
      sub_idx  <= '0;
      beat_idx <= '0;
      oversize <= 1'b0;
      busy     <= 1'b1;
    end else begin
      if (accept && in_last) armed <= 1'b0;
      if (accept && drop)    oversize <= 1'b1;
      if (use_data) begin
        if (close) begin
          beat_idx <= '0;
          sub_idx  <= sub_idx + 1'b1;
        end else begin
          beat_idx <= beat_idx + 1'b1;
        end
      end
      if (s_valid && s_last) busy <= 1'b0;
    end
  end

  ecc_beat_stage #(
    .DATA_W    (DATA_W),
    .BEAT_IDX_W(BEAT_IDX_W),
    .SUB_W     (SUB_W)
  ) u_beat (
    .clk     (clk),
    .rst     (rst),
    .clear   (start),
    .fwd     (accept),
    .use_data(use_data),
    .close   (close),
    .last    (in_last),
    .sub     (sub_idx[SUB_W-1:0]),
    .beat_idx(beat_idx),
    .data    (in_data),
    .s_valid (s_valid),
    .s_close (s_close),
    .s_last  (s_last),
    .s_sub   (s_sub),
    .s_odd   (s_odd),
    .s_even  (s_even)
  );

  ecc_accum #(
    .HALF_W(HALF_W),
    .SUB_W (SUB_W)
  ) u_acc (
    .clk    (clk),
    .rst    (rst),
    .clear  (start),
    .s_valid(s_valid),
    .s_close(s_close),
    .s_sub  (s_sub),
    .s_odd  (s_odd),
    .s_even (s_even),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .wr_code(wr_code)
  );

  ecc_result_bank #(
    .NUM_SUB(NUM_SUB),
    .CODE_W (CODE_W)
  ) u_bank (
    .clk    (clk),
    .rst    (rst),
    .clear  (start),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .wr_code(wr_code),
    .rd_addr(rd_addr),
    .rd_data(rd_data)
  );

endmodule

// File: rtl/ecc_page_gen_checker.sv
module ecc_page_gen_checker (
  input logic        clk,
  input logic        rst,
  input logic        start,
  input logic        in_valid,
  input logic        in_last,
  input logic [31:0] rd_data,
  input logic        busy,
  input logic        oversize
);

  // Input rule: a beat never shares a cycle with the arming strobe.
  assert_no_beat_on_start_R6: assert property (@(posedge clk) disable iff (rst)
    !(start && in_valid));

  assert_busy_after_start_R5: assert property (@(posedge clk) disable iff (rst)
    start |=> busy);

  assert_busy_falls_after_last_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(in_valid && in_last, 2));

  assert_start_clears_flag_R6: assert property (@(posedge clk) disable iff (rst)
    start |=> !oversize);

  assert_start_clears_slots_R6: assert property (@(posedge clk) disable iff (rst)
    start |=> ##1 (rd_data == 32'h0));

  assert_status_encoding_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_data[31:24] != 8'h40) |-> (rd_data == 32'h0));

  assert_oversize_while_busy_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(oversize) |-> $past(busy));

endmodule

bind ecc_page_gen ecc_page_gen_checker u_chk (.*);

// File: tb/ecc_page_gen_test.sv
module ecc_page_gen_test;

  localparam int CLK_PERIOD = 10;
  localparam int PAGE_MAX   = 2560;

  logic        clk = 1'b0;
  logic        rst, start, in_valid, in_last;
  logic [31:0] in_data;
  logic [1:0]  rd_addr;
  logic [31:0] rd_data;
  logic        busy, oversize;

  ecc_page_gen uut (
    .clk(clk), .rst(rst), .start(start), .in_valid(in_valid),
    .in_data(in_data), .in_last(in_last), .rd_addr(rd_addr),
    .rd_data(rd_data), .busy(busy), .oversize(oversize)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [7:0]  page [PAGE_MAX];
  int          checks = 0;
  int          failures = 0;
  logic        rd_req = 1'b0;
  logic        mon_pend = 1'b0;
  logic [31:0] exp_q [$];
  string       tag_q [$];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: pops one expectation per read result.
  always @(posedge clk) mon_pend <= rd_req;
  always @(negedge clk) begin
    if (mon_pend && exp_q.size() > 0) begin
      chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
  end

  function automatic logic [23:0] ref_code(input int base, input int cnt);
    logic [11:0] odd, even, pos;
    odd = '0;
    even = '0;
    for (int j = 0; j < cnt; j++) begin
      for (int b = 0; b < 8; b++) begin
        if (page[base + j][b]) begin
          pos  = 12'(j * 8 + b);
          odd  = odd ^ pos;
          even = even ^ ~pos;
        end
      end
    end
    return {even, odd};
  endfunction

  task automatic read_reg(input int a, input logic [31:0] exp, input string tag);
    rd_addr = 2'(a);
    rd_req  = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_req  = 1'b0;
  endtask

  task automatic check_regs(input int nbytes, input string tag);
    for (int s = 0; s < 4; s++) begin
      int cnt;
      cnt = nbytes - s * 512;
      if (cnt > 512) cnt = 512;
      if (cnt > 0) read_reg(s, {8'h40, ref_code(s * 512, cnt)}, tag);
      else         read_reg(s, 32'h0, tag);
    end
    @(negedge clk);
  endtask

  task automatic put_beat(input logic [31:0] d, input logic last);
    in_valid = 1'b1;
    in_data  = d;
    in_last  = last;
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
    in_data  = $urandom;
  endtask

  task automatic send_range(input int first, input int nbytes, input bit last_end, input bit gaps);
    for (int b = 0; b < nbytes / 4; b++) begin
      int i;
      if (gaps && ($urandom % 3 == 0)) repeat (1 + $urandom % 2) @(negedge clk);
      i = first + 4 * b;
      put_beat({page[i+3], page[i+2], page[i+1], page[i]}, last_end && (b == nbytes / 4 - 1));
    end
  endtask

  task automatic do_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic fill_random();
    for (int i = 0; i < PAGE_MAX; i++) page[i] = 8'($urandom);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1; start = 1'b0; in_valid = 1'b0; in_last = 1'b0;
    in_data = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // Reset state
    chk("R5 busy after reset", 32'(busy), 32'h0);
    chk("R7 oversize after reset", 32'(oversize), 32'h0);
    check_regs(0, "R3 empty slot after reset");

    // Known-answer codes and lane order
    for (int i = 0; i < PAGE_MAX; i++) page[i] = 8'h00;
    page[300] = 8'h20;
    page[513] = 8'h01;
    do_start();
    chk("R5 busy after start", 32'(busy), 32'h1);
    send_range(0, 1024, 1'b1, 1'b0);
    chk("R5 busy until last processed", 32'(busy), 32'h1);
    @(negedge clk);
    chk("R5 busy falls after last", 32'(busy), 32'h0);
    read_reg(0, 32'h4069A965, "R1 single bit at byte 300 bit 5");
    read_reg(1, 32'h40FF7008, "R1 byte lane 1 bit 0 R9");
    read_reg(2, 32'h0, "R3 unused slot");
    @(negedge clk);

    // Full page with idle gaps, slot 0 valid mid page
    fill_random();
    do_start();
    send_range(0, 512, 1'b0, 1'b1);
    repeat (2) @(negedge clk);
    chk("R5 busy during page", 32'(busy), 32'h1);
    read_reg(0, {8'h40, ref_code(0, 512)}, "R4 slot valid mid page R10");
    read_reg(1, 32'h0, "R3 slot not yet valid");
    send_range(512, 1536, 1'b1, 1'b1);
    repeat (2) @(negedge clk);
    check_regs(2048, "R2 full page with gaps R10");

    // Partial final sub-block
    fill_random();
    do_start();
    send_range(0, 1000, 1'b1, 1'b0);
    repeat (2) @(negedge clk);
    check_regs(1000, "R4 partial sub-block");

    // Beats after page end are ignored
    for (int b = 0; b < 20; b++) put_beat($urandom, b == 19);
    repeat (2) @(negedge clk);
    chk("R8 busy stays low", 32'(busy), 32'h0);
    chk("R8 oversize untouched", 32'(oversize), 32'h0);
    check_regs(1000, "R8 stray beats ignored");

    // Abort mid page
    fill_random();
    do_start();
    send_range(0, 600, 1'b0, 1'b0);
    do_start();
    chk("R6 busy after restart", 32'(busy), 32'h1);
    @(negedge clk);
    check_regs(0, "R6 slots cleared by start");
    fill_random();
    send_range(0, 2048, 1'b1, 1'b0);
    repeat (2) @(negedge clk);
    check_regs(2048, "R6 clean page after abort");

    // Overlong page
    fill_random();
    do_start();
    send_range(0, 2400, 1'b1, 1'b1);
    repeat (2) @(negedge clk);
    chk("R7 oversize set", 32'(oversize), 32'h1);
    chk("R7 busy falls on overlong page", 32'(busy), 32'h0);
    check_regs(2048, "R7 stored codes unchanged");
    do_start();
    chk("R6 oversize cleared", 32'(oversize), 32'h0);

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end

endmodule